// File: doc/BRIEF.md
# ADC Conversion Chain Sequencer

This block is the control state machine that decides which analog channel an ADC converts next, and when. Software enables channels in two masks. The normal chain walks the normal mask once per start, or repeats it without a break in scan mode. The injected chain walks the injected mask. It is started by a software pulse or by a chosen edge on an external trigger line. An injected chain always has priority over the normal chain and always runs to its end.

The analog converter is modelled as two timed phases. A sample phase is followed by a convert phase, and each phase length comes from a cycle-count input. Every completed conversion produces a one-cycle done pulse. The pulse carries the channel number and a source tag, so that a result store outside this block can file the converted value.

Two abort controls are provided. One drops only the conversion in progress. The other ends the whole normal chain. A power-down request parks the sequencer while nothing is pending. Status outputs give the following:
- busy flags for both chains
- the channel in work
- a 3-bit phase code

Top module: `adc_chain_seq`

## Requirements
- R1: After reset, `state_code` is 000, and `norm_busy`, `inj_busy`, `done_valid`, `abort_conv_flag`, `abort_chain_flag` and `inj_aborted` are all 0.
- R2: A `nstart_set` pulse with a nonzero `norm_mask` raises `norm_busy`. Each enabled channel is then converted once, in ascending index order, and each conversion gives a one-cycle `done_valid` with `done_chan` set to the channel and `done_src` set to 0 (normal). `norm_busy` falls after the last channel. A start with an all-zero `norm_mask` is ignored.
- R3: Phase timing works as follows. One idle dispatch cycle comes first. `state_code` then reads 100 (sampling) for `samp_cycles` cycles and 110 (converting) for `conv_cycles` cycles, where a count of 0 acts as 1. In the cycle after the last convert cycle, `state_code` reads 000 and `done_valid` is 1.
- R4: With `scan_mode` = 1, the normal chain restarts from the lowest enabled channel after it completes. A `nstart_clr` pulse lets the chain in progress finish, and then the sequencer stops.
- R5: An `inj_start_set` pulse with a nonzero `inj_mask` raises `inj_busy`. The enabled injected channels are then converted in ascending order, with `done_src` = 1 (injected).
- R6: With `trig_en` = 1, an edge on `trig_in` starts the injected chain. The edge is rising when `trig_rising` = 1 and falling when `trig_rising` = 0. The other edge is ignored, and with `trig_en` = 0 every edge is ignored.
- R7: An injected request made during a normal conversion waits until that conversion ends. The injected chain runs next, and the normal chain then resumes at its next channel. `norm_busy` stays 1 throughout.
- R8: A running injected chain cannot be interrupted. A further injected request and an `abort_chain_set` pulse both leave it converting every enabled channel exactly once.
- R9: `abort_conv_set` during a conversion drops that conversion with no done pulse, and the chain continues with its next channel. `abort_conv_flag` stays 1 until the next sample phase begins. An aborted injected conversion sets `inj_aborted`, which clears when a new injected chain is accepted.
- R10: `abort_chain_set` ends the normal chain at once. `norm_busy` falls, and no further normal done pulses follow. `abort_chain_flag` stays 1 until a new start request is accepted.
- R11: `pwdn_req` = 1 while nothing is pending moves `state_code` to 001 after one clock. Start requests have no effect while powered down. Clearing `pwdn_req` returns `state_code` to 000 after one clock.
- R12: During the sample and convert phases, `cur_chan` shows the channel being converted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| norm_mask | input | NCH | Channels enabled in the normal chain |
| inj_mask | input | NCH | Channels enabled in the injected chain |
| scan_mode | input | 1 | 1 = repeat the normal chain, 0 = run it once |
| samp_cycles | input | CW | Sample phase length in cycles (0 acts as 1) |
| conv_cycles | input | CW | Convert phase length in cycles (0 acts as 1) |
| nstart_set | input | 1 | Pulse: start the normal chain |
| nstart_clr | input | 1 | Pulse: stop the normal chain after the current chain |
| inj_start_set | input | 1 | Pulse: start the injected chain |
| trig_en | input | 1 | Enables the external injection trigger |
| trig_rising | input | 1 | Trigger edge: 1 = rising, 0 = falling |
| trig_in | input | 1 | External trigger line |
| abort_conv_set | input | 1 | Pulse: drop the conversion in progress |
| abort_chain_set | input | 1 | Pulse: end the normal chain |
| pwdn_req | input | 1 | Power-down request level |
| norm_busy | output | 1 | Normal chain running or pending |
| inj_busy | output | 1 | Injected chain running |
| abort_conv_flag | output | 1 | Single-conversion abort pending/seen |
| abort_chain_flag | output | 1 | Chain abort seen |
| inj_aborted | output | 1 | An injected conversion was aborted |
| cur_chan | output | log2(NCH) | Channel in the sample or convert phase |
| state_code | output | 3 | 000 idle, 001 power-down, 100 sample, 110 convert |
| done_valid | output | 1 | One-cycle pulse: a conversion completed |
| done_chan | output | log2(NCH) | Channel of the completed conversion |
| done_src | output | 1 | 0 = normal, 1 = injected |

## Verification
The bench injects a request while a normal conversion is in progress. It then checks the exact interleaving of channels and source tags. A design that preempted the conversion, or restarted the normal chain from channel 0, would log the wrong sequence. Aborts are issued in both the sample and the convert phase. The bench checks that the dropped channel never appears, that the chain continues, and that each flag clears only at its own event. A design that mixed up the two self-clear rules would leave a flag stale, or clear it too early. Scan stop, a zero mask, zero phase counts and the ignored trigger edge are each driven. A design that ignored the stop request would loop forever. One that miscounted the phases would show the wrong phase code on an exact cycle.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PWDN = 2'd1,
    ST_SAMP = 2'd2,
    ST_CONV = 2'd3
  } seq_state_e;

  typedef enum logic {
    SRC_NORM = 1'b0,
    SRC_INJ  = 1'b1
  } conv_src_e;

  localparam logic [2:0] CODE_IDLE = 3'b000;
  localparam logic [2:0] CODE_PWDN = 3'b001;
  localparam logic [2:0] CODE_SAMP = 3'b100;
  localparam logic [2:0] CODE_CONV = 3'b110;

  function automatic logic [2:0] state_code_of(seq_state_e s);
    case (s)
      ST_PWDN: return CODE_PWDN;
      ST_SAMP: return CODE_SAMP;
      ST_CONV: return CODE_CONV;
      default: return CODE_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/adcseq_edge_det.sv
module adcseq_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_in,
  input  logic rising_sel,
  output logic hit
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sig_in;
  end

  assign hit = rising_sel ? (sig_in & ~prev_q) : (~sig_in & prev_q);

  // R6: a reported edge always means the line differs from last cycle
  a_r6_edge_is_change: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (sig_in != prev_q));
endmodule

// File: rtl/adcseq_phase_timer.sv
module adcseq_phase_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [CW-1:0] len,
  output logic          last
);
  logic [CW-1:0] cnt_q;

  // index of the final cycle of a phase; a zero length behaves as one cycle
  function automatic logic [CW-1:0] final_index(logic [CW-1:0] l);
    return (l == '0) ? '0 : l - CW'(1);
  endfunction

  assign last = (cnt_q >= final_index(len));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else if (!last)   cnt_q <= cnt_q + CW'(1);
  end

  // R3: a restarted phase always begins at its first cycle
  a_r3_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));
endmodule

// File: rtl/adcseq_chan_pick.sv
module adcseq_chan_pick #(
  parameter int NCH = 16,
  parameter int CHW = 4,
  parameter int PW  = 5
) (
  input  logic [NCH-1:0] mask,
  input  logic [PW-1:0]  from,
  output logic           found,
  output logic [CHW-1:0] idx
);
  // lowest enabled channel whose index is not below 'from'
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (mask[i] && (i >= int'(from))) begin
        found = 1'b1;
        idx   = CHW'(i);
      end
    end
  end
endmodule

// File: rtl/adc_chain_seq.sv
module adc_chain_seq
  import adcseq_pkg::*;
#(
  parameter int NCH = 16,
  parameter int CW  = 8,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int PW  = $clog2(NCH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] norm_mask,
  input  logic [NCH-1:0] inj_mask,
  input  logic           scan_mode,
  input  logic [CW-1:0]  samp_cycles,
  input  logic [CW-1:0]  conv_cycles,
  input  logic           nstart_set,
  input  logic           nstart_clr,
  input  logic           inj_start_set,
  input  logic           trig_en,
  input  logic           trig_rising,
  input  logic           trig_in,
  input  logic           abort_conv_set,
  input  logic           abort_chain_set,
  input  logic           pwdn_req,
  output logic           norm_busy,
  output logic           inj_busy,
  output logic           abort_conv_flag,
  output logic           abort_chain_flag,
  output logic           inj_aborted,
  output logic [CHW-1:0] cur_chan,
  output logic [2:0]     state_code,
  output logic           done_valid,
  output logic [CHW-1:0] done_chan,
  output logic           done_src
);

  seq_state_e     state_q;
  conv_src_e      src_q;
  logic [CHW-1:0] cur_q;
  logic           norm_active, inj_active, stop_req;
  logic [PW-1:0]  norm_ptr, inj_ptr;
  logic           ab_conv_q, ab_chain_q, inj_ab_q;
  logic           done_q, done_src_q;
  logic [CHW-1:0] done_chan_q;

  // named internal events
  logic           trig_hit, inj_req, inj_accept, norm_accept;
  logic           in_conv, abort_now, chain_kill, kill_cur_norm, drop_cur;
  logic           phase_last, phase_enter;
  logic           inj_found, norm_found;
  logic [CHW-1:0] inj_idx, norm_idx;
  logic           go_inj, go_norm, inj_chain_end, norm_wrap, go_pwdn, conv_finish;
  logic [CW-1:0]  phase_len;

  adcseq_edge_det u_trig (
    .clk(clk), .rst_n(rst_n), .sig_in(trig_in),
    .rising_sel(trig_rising), .hit(trig_hit)
  );

  adcseq_chan_pick #(.NCH(NCH), .CHW(CHW), .PW(PW)) u_pick_inj (
    .mask(inj_mask), .from(inj_ptr), .found(inj_found), .idx(inj_idx)
  );

  adcseq_chan_pick #(.NCH(NCH), .CHW(CHW), .PW(PW)) u_pick_norm (
    .mask(norm_mask), .from(norm_ptr), .found(norm_found), .idx(norm_idx)
  );

  assign phase_len = (state_q == ST_CONV) ? conv_cycles : samp_cycles;

  adcseq_phase_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(phase_enter),
    .len(phase_len), .last(phase_last)
  );

  function automatic logic [PW-1:0] after(logic [CHW-1:0] c);
    return PW'(c) + PW'(1);
  endfunction

  always_comb begin
    inj_req       = inj_start_set | (trig_en & trig_hit);
    inj_accept    = inj_req & ~inj_active & (|inj_mask) & (state_q != ST_PWDN);
    norm_accept   = nstart_set & ~norm_active & (|norm_mask) & (state_q != ST_PWDN);
    in_conv       = (state_q == ST_SAMP) || (state_q == ST_CONV);
    abort_now     = abort_conv_set & in_conv;
    chain_kill    = abort_chain_set & norm_active;
    kill_cur_norm = chain_kill & in_conv & (src_q == SRC_NORM);
    drop_cur      = abort_now | kill_cur_norm;
    go_inj        = (state_q == ST_IDLE) & inj_active & inj_found;
    inj_chain_end = (state_q == ST_IDLE) & inj_active & ~inj_found;
    go_norm       = (state_q == ST_IDLE) & ~inj_active & norm_active & norm_found
                    & ~abort_chain_set;
    norm_wrap     = (state_q == ST_IDLE) & ~inj_active & norm_active & ~norm_found;
    go_pwdn       = (state_q == ST_IDLE) & ~inj_active & ~norm_active & pwdn_req
                    & ~norm_accept & ~inj_accept;
    conv_finish   = (state_q == ST_CONV) & phase_last & ~drop_cur;
    phase_enter   = go_inj | go_norm | ((state_q == ST_SAMP) & phase_last & ~drop_cur);
  end

  // phase state, current channel and completion pulse
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      src_q       <= SRC_NORM;
      cur_q       <= '0;
      done_q      <= 1'b0;
      done_chan_q <= '0;
      done_src_q  <= 1'b0;
    end else begin
      done_q <= conv_finish;
      if (conv_finish) begin
        done_chan_q <= cur_q;
        done_src_q  <= src_q;
      end
      case (state_q)
        ST_IDLE: begin
          if (go_inj) begin
            state_q <= ST_SAMP;
            src_q   <= SRC_INJ;
            cur_q   <= inj_idx;
          end else if (go_norm) begin
            state_q <= ST_SAMP;
            src_q   <= SRC_NORM;
            cur_q   <= norm_idx;
          end else if (go_pwdn) begin
            state_q <= ST_PWDN;
          end
        end
        ST_PWDN: if (!pwdn_req) state_q <= ST_IDLE;
        ST_SAMP: begin
          if (drop_cur)        state_q <= ST_IDLE;
          else if (phase_last) state_q <= ST_CONV;
        end
        default: begin
          if (drop_cur || phase_last) state_q <= ST_IDLE;
        end
      endcase
    end
  end

  // chain bookkeeping
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      norm_active <= 1'b0;
      inj_active  <= 1'b0;
      stop_req    <= 1'b0;
      norm_ptr    <= '0;
      inj_ptr     <= '0;
    end else begin
      if (inj_accept) begin
        inj_active <= 1'b1;
        inj_ptr    <= '0;
      end else if (inj_chain_end) begin
        inj_active <= 1'b0;
      end else if (go_inj) begin
        inj_ptr <= after(inj_idx);
      end

      if (norm_accept) begin
        norm_active <= 1'b1;
        norm_ptr    <= '0;
      end else if (chain_kill) begin
        norm_active <= 1'b0;
      end else if (norm_wrap) begin
        if (scan_mode && !stop_req) norm_ptr    <= '0;
        else                        norm_active <= 1'b0;
      end else if (go_norm) begin
        norm_ptr <= after(norm_idx);
      end

      if (nstart_set)                    stop_req <= 1'b0;
      else if (nstart_clr && norm_active) stop_req <= 1'b1;
    end
  end

  // abort flags with their own self-clear events
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ab_conv_q  <= 1'b0;
      ab_chain_q <= 1'b0;
      inj_ab_q   <= 1'b0;
    end else begin
      if (abort_conv_set)          ab_conv_q <= 1'b1;
      else if (go_inj || go_norm)  ab_conv_q <= 1'b0;

      if (abort_chain_set)                 ab_chain_q <= 1'b1;
      else if (norm_accept || inj_accept)  ab_chain_q <= 1'b0;

      if (abort_now && src_q == SRC_INJ) inj_ab_q <= 1'b1;
      else if (inj_accept)               inj_ab_q <= 1'b0;
    end
  end

  assign norm_busy        = norm_active;
  assign inj_busy         = inj_active;
  assign abort_conv_flag  = ab_conv_q;
  assign abort_chain_flag = ab_chain_q;
  assign inj_aborted      = inj_ab_q;
  assign cur_chan         = cur_q;
  assign state_code       = state_code_of(state_q);
  assign done_valid       = done_q;
  assign done_chan        = done_chan_q;
  assign done_src         = done_src_q;

  // R3: only the four defined codes ever appear
  a_r3_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == CODE_IDLE) || (state_code == CODE_PWDN) ||
    (state_code == CODE_SAMP) || (state_code == CODE_CONV));

  // R3: a completion pulse follows a convert phase
  a_r3_done_after_conv: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> ($past(state_q) == ST_CONV));

  // R7: a pending injected channel is dispatched before any normal one
  a_r7_inj_first: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && inj_active && inj_found) |=>
      (state_q == ST_SAMP && src_q == SRC_INJ));

  // R8: the injected chain ends only at a dispatch point, never mid-conversion
  a_r8_inj_uninterrupted: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(inj_active) |-> ($past(state_q) == ST_IDLE));

  // R9: a dropped conversion produces no completion pulse
  a_r9_no_done_on_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CONV && drop_cur) |=> !done_valid);

  // R11: power-down is held only with no chain outstanding
  a_r11_pwdn_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PWDN) |-> (!norm_active && !inj_active));

endmodule

// File: tb/adc_chain_seq_tb.sv
module adc_chain_seq_tb;
  localparam int NCH     = 16;
  localparam int CW      = 8;
  localparam int CLK_PER = 10;
  localparam int WDOG    = 150000;

  // vector fields: [31:16] normal mask, [15:8] sample count, [7:0] convert count
  localparam logic [31:0] VEC [6] = '{
    32'h0001_0101, 32'h8001_0203, 32'h0F0F_0000,
    32'hAAAA_0102, 32'hFFFF_0101, 32'h0000_0101
  };

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] norm_mask = '0, inj_mask = '0;
  logic           scan_mode = 1'b0;
  logic [CW-1:0]  samp_cycles = 8'd1, conv_cycles = 8'd1;
  logic           nstart_set = 0, nstart_clr = 0, inj_start_set = 0;
  logic           trig_en = 0, trig_rising = 1, trig_in = 0;
  logic           abort_conv_set = 0, abort_chain_set = 0, pwdn_req = 0;
  logic           norm_busy, inj_busy, abort_conv_flag, abort_chain_flag, inj_aborted;
  logic [3:0]     cur_chan, done_chan;
  logic [2:0]     state_code;
  logic           done_valid, done_src;

  int n_chk = 0, n_bad = 0;
  int log_n = 0;
  int log_chan [256];
  int log_src  [256];
  int exp_chan [64];
  int exp_src  [64];
  int exp_n;

  always #(CLK_PER/2) clk = ~clk;

  adc_chain_seq #(.NCH(NCH), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .norm_mask(norm_mask), .inj_mask(inj_mask),
    .scan_mode(scan_mode), .samp_cycles(samp_cycles), .conv_cycles(conv_cycles),
    .nstart_set(nstart_set), .nstart_clr(nstart_clr), .inj_start_set(inj_start_set),
    .trig_en(trig_en), .trig_rising(trig_rising), .trig_in(trig_in),
    .abort_conv_set(abort_conv_set), .abort_chain_set(abort_chain_set),
    .pwdn_req(pwdn_req), .norm_busy(norm_busy), .inj_busy(inj_busy),
    .abort_conv_flag(abort_conv_flag), .abort_chain_flag(abort_chain_flag),
    .inj_aborted(inj_aborted), .cur_chan(cur_chan), .state_code(state_code),
    .done_valid(done_valid), .done_chan(done_chan), .done_src(done_src)
  );

  always @(posedge clk) begin
    if (rst_n && done_valid) begin
      if (log_n < 256) begin
        log_chan[log_n] = int'(done_chan);
        log_src[log_n]  = int'(done_src);
      end
      log_n = log_n + 1;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // sel: 0 nstart_set, 1 nstart_clr, 2 inj_start_set, 3 abort_conv_set, 4 abort_chain_set
  task automatic pulse(input logic [4:0] sel);
    @(negedge clk);
    nstart_set = sel[0]; nstart_clr = sel[1]; inj_start_set = sel[2];
    abort_conv_set = sel[3]; abort_chain_set = sel[4];
    @(negedge clk);
    nstart_set = 0; nstart_clr = 0; inj_start_set = 0;
    abort_conv_set = 0; abort_chain_set = 0;
  endtask

  task automatic wait_quiet();
    do @(negedge clk); while (norm_busy || inj_busy || state_code != 3'b000);
    repeat (3) @(negedge clk);
  endtask

  task automatic exp_clear(); exp_n = 0; endtask
  task automatic exp_push(input int ch, input int src);
    exp_chan[exp_n] = ch; exp_src[exp_n] = src; exp_n++;
  endtask
  task automatic exp_from_mask(input logic [NCH-1:0] m, input int src);
    for (int i = 0; i < NCH; i++) if (m[i]) exp_push(i, src);
  endtask

  task automatic cmp_log(input string req, input int mark);
    chk(req, "done count", log_n - mark, exp_n);
    for (int i = 0; i < exp_n && mark + i < log_n; i++) begin
      chk(req, "done channel", log_chan[mark + i], exp_chan[i]);
      chk(req, "done source", log_src[mark + i], exp_src[i]);
    end
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    int mark;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "state_code", state_code, 0);
    chk("R1", "busy flags", {norm_busy, inj_busy, done_valid}, 0);
    chk("R1", "abort flags", {abort_conv_flag, abort_chain_flag, inj_aborted}, 0);

    // R2 one-shot vectors, including zero phase counts and a zero mask
    for (int v = 0; v < 6; v++) begin
      norm_mask   = VEC[v][31:16];
      samp_cycles = VEC[v][15:8];
      conv_cycles = VEC[v][7:0];
      mark = log_n;
      pulse(5'b00001);
      chk("R2", "busy after start", norm_busy, (VEC[v][31:16] != 0) ? 1 : 0);
      wait_quiet();
      exp_clear();
      exp_from_mask(VEC[v][31:16], 0);
      cmp_log("R2", mark);
    end

    // R3 and R12 exact phase timing and channel report
    norm_mask = 16'h0004; samp_cycles = 8'd3; conv_cycles = 8'd2;
    pulse(5'b00001);
    chk("R3", "dispatch cycle code", state_code, 0);
    for (int n = 1; n <= 5; n++) begin
      @(negedge clk);
      chk("R3", "phase code", state_code, (n <= 3) ? 4 : 6);
      chk("R12", "cur_chan", cur_chan, 2);
    end
    @(negedge clk);
    chk("R3", "done after convert", done_valid, 1);
    chk("R3", "done channel", done_chan, 2);
    @(negedge clk);
    chk("R3", "done is one cycle", done_valid, 0);
    chk("R2", "busy after chain", norm_busy, 0);

    // R4 scan restart and stop at chain end
    norm_mask = 16'h0005; samp_cycles = 8'd1; conv_cycles = 8'd1; scan_mode = 1;
    mark = log_n;
    pulse(5'b00001);
    while (log_n - mark < 5) @(negedge clk);
    pulse(5'b00010);
    wait_quiet();
    chk("R4", "even count", (log_n - mark) % 2, 0);
    chk("R4", "restarted", (log_n - mark) >= 6 ? 1 : 0, 1);
    chk("R4", "chain pattern", log_chan[mark + 2], 0);
    chk("R4", "ends on last channel", log_chan[log_n - 1], 2);
    scan_mode = 0;

    // R5 and R7 injection during a normal conversion
    norm_mask = 16'h000F; inj_mask = 16'h0030; samp_cycles = 8'd2; conv_cycles = 8'd2;
    mark = log_n;
    pulse(5'b00001);
    while (!(log_n - mark == 1 && state_code == 3'b100)) @(negedge clk);
    pulse(5'b00100);
    chk("R5", "inj_busy", inj_busy, 1);
    while (!(state_code == 3'b100 && cur_chan == 4)) @(negedge clk);
    chk("R7", "normal pending during injection", norm_busy, 1);
    wait_quiet();
    exp_clear();
    exp_push(0, 0); exp_push(1, 0); exp_push(4, 1); exp_push(5, 1);
    exp_push(2, 0); exp_push(3, 0);
    cmp_log("R7", mark);

    // R8 injected chain cannot be interrupted
    norm_mask = 16'h0000; inj_mask = 16'h0007;
    mark = log_n;
    pulse(5'b00100);
    while (!(state_code == 3'b100 && cur_chan == 1)) @(negedge clk);
    pulse(5'b10100);
    wait_quiet();
    exp_clear(); exp_from_mask(16'h0007, 1);
    cmp_log("R8", mark);
    chk("R10", "chain flag held", abort_chain_flag, 1);

    // R6 trigger edges
    inj_mask = 16'h0100; trig_en = 1; trig_rising = 1;
    mark = log_n;
    @(negedge clk); trig_in = 1;
    wait_quiet();
    exp_clear(); exp_push(8, 1);
    cmp_log("R6", mark);
    chk("R10", "flag cleared by accept", abort_chain_flag, 0);
    mark = log_n;
    @(negedge clk); trig_in = 0;
    repeat (10) @(negedge clk);
    chk("R6", "falling ignored in rising mode", log_n - mark + int'(inj_busy), 0);
    trig_rising = 0;
    @(negedge clk); trig_in = 1;
    repeat (10) @(negedge clk);
    chk("R6", "rising ignored in falling mode", log_n - mark + int'(inj_busy), 0);
    @(negedge clk); trig_in = 0;
    wait_quiet();
    exp_clear(); exp_push(8, 1);
    cmp_log("R6", mark);
    trig_en = 0; mark = log_n;
    @(negedge clk); trig_in = 1;
    @(negedge clk); trig_in = 0;
    repeat (10) @(negedge clk);
    chk("R6", "disabled trigger", log_n - mark + int'(inj_busy), 0);

    // R9 abort one normal conversion
    norm_mask = 16'h0007; samp_cycles = 8'd2; conv_cycles = 8'd3;
    mark = log_n;
    pulse(5'b00001);
    while (!(state_code == 3'b110 && cur_chan == 1)) @(negedge clk);
    pulse(5'b01000);
    chk("R9", "abort flag set", abort_conv_flag, 1);
    chk("R9", "back to idle", state_code, 0);
    @(negedge clk);
    chk("R9", "next channel sampling", cur_chan, 2);
    chk("R9", "flag cleared at sample start", abort_conv_flag, 0);
    wait_quiet();
    exp_clear(); exp_push(0, 0); exp_push(2, 0);
    cmp_log("R9", mark);

    // R9 abort an injected conversion
    norm_mask = 16'h0000; inj_mask = 16'h0003;
    mark = log_n;
    pulse(5'b00100);
    while (!(state_code == 3'b100 && cur_chan == 0)) @(negedge clk);
    pulse(5'b01000);
    chk("R9", "inj_aborted set", inj_aborted, 1);
    wait_quiet();
    exp_clear(); exp_push(1, 1);
    cmp_log("R9", mark);
    pulse(5'b00100);
    chk("R9", "inj_aborted cleared", inj_aborted, 0);
    wait_quiet();

    // R10 abort the whole normal chain in scan mode
    norm_mask = 16'h000F; scan_mode = 1;
    mark = log_n;
    pulse(5'b00001);
    while (!(state_code == 3'b100 && cur_chan == 1)) @(negedge clk);
    pulse(5'b10000);
    chk("R10", "norm_busy dropped", norm_busy, 0);
    chk("R10", "chain flag set", abort_chain_flag, 1);
    wait_quiet();
    exp_clear(); exp_push(0, 0);
    cmp_log("R10", mark);
    scan_mode = 0; norm_mask = 16'h0001;
    pulse(5'b00001);
    chk("R10", "chain flag cleared", abort_chain_flag, 0);
    wait_quiet();

    // R11 power-down
    @(negedge clk); pwdn_req = 1;
    @(negedge clk);
    chk("R11", "powered down code", state_code, 1);
    mark = log_n;
    pulse(5'b00101);
    repeat (5) @(negedge clk);
    chk("R11", "starts ignored", log_n - mark + int'(norm_busy) + int'(inj_busy), 0);
    chk("R11", "still powered down", state_code, 1);
    pwdn_req = 0;
    @(negedge clk);
    chk("R11", "back to idle", state_code, 0);

    summary();
    $finish;
  end
endmodule